// File: doc/BRIEF.md
# Address Access Protection Checker

This block screens every processor transaction against eight programmable protection regions. Each region has two registers. The base register holds the region's page address, its permission flags and an enable bit. The size register holds a length mask. When a request address falls inside one or more enabled regions, the block compares the transaction kind against the forbidding flags of those regions. It then returns an allow/deny decision and a flag that marks a cacheable request into a region where caching is forbidden.

The block has its own small, window of on-chip registers, whose base page comes in on an input. That window is exempt from protection: a request that targets it is always allowed, even when an enabled region overlaps it. Software programs the regions through a simple write port. The request side is a single-beat valid/address interface, and the registered decision appears one clock after the request.

Top module: `prot_checker`

## Requirements
- R1: After reset every region is disabled and closed, so every request is allowed; while reset is held, `rsp_valid` is low.
- R2: Each request presented with `req_valid` high yields `rsp_valid` high on the next clock edge, carrying the decision. A clock edge without a request gives `rsp_valid`, `rsp_allow` and `rsp_cache_deny` all low.
- R3: Region n has its base register at byte offset 0x10*n and its size register at 0x10*n+4. In the base register, bits 19:0 are address bits 35:16, bit 20 forbids all access, bit 21 forbids writes, bit 22 forbids caching and bit 31 enables the region. All other bits are ignored.
- R4: Size register bits 19:0 hold the region length in 64 KB pages minus one, as a run of ones from bit 0. The low four bits always act as ones, so the smallest region is 1 MB.
- R5: A region matches when address bits 35:16 equal its base on every bit outside the size mask. Base bits under the mask are ignored.
- R6: A region with its enable bit clear, or with a size register of zero, matches nothing.
- R7: A request that matches a region with the access-forbidden bit set is denied, whether it is a read or a write.
- R8: A write that matches a region with the write-forbidden bit set is denied. A read that matches such a region is allowed.
- R9: `rsp_cache_deny` is high when a cacheable request matches a region with the cache-forbidden bit set. This flag never changes `rsp_allow`.
- R10: When several enabled regions match, the request is denied if any of them forbids it, and the cache flags of all of them are ORed.
- R11: A request that matches no region is allowed, and `rsp_cache_deny` stays low.
- R12: A request whose address bits 35:16 equal `int_page` is always allowed, with `rsp_cache_deny` low, whatever the regions say.
- R13: Configuration writes to offsets 0x8 and 0xC within a region's 16-byte slot change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_page | input | 20 | Address bits 35:16 of the exempt internal register window |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 36 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cacheable | input | 1 | Request wants to be cached |
| rsp_valid | output | 1 | Decision valid, one clock after the request |
| rsp_allow | output | 1 | 1 = access permitted |
| rsp_cache_deny | output | 1 | Cacheable request hit a cache-forbidden region |

## Verification
The hardest cases to reach are the overlaps. One needs an address covered at the same time by two regions with different flags, by the internal window and a forbidding region, and by a region whose size value is below the 1 MB floor or whose base has stray bits under its mask. The bench programs one configuration that builds all of these at once inside the first 256 pages. It then sweeps every page there with all four read/write and cacheable combinations, against a range model (low bound to high bound) kept in the bench. It reprograms, disables and closes regions and repeats the sweep, and it probes the edges of a region placed high in the 36-bit space.

// File: rtl/prot_pkg.sv
package prot_pkg;
  // Address bits above one 64 KB page form the page number.
  localparam int PAGE_LSB      = 16;
  localparam int PAGE_W        = 20;
  localparam int ADDR_W        = PAGE_W + PAGE_LSB;
  // The smallest region is 2**FLOOR_BITS pages (1 MB).
  localparam int FLOOR_BITS    = 4;
  localparam logic [PAGE_W-1:0] FLOOR_MASK = PAGE_W'((1 << FLOOR_BITS) - 1);

  // Field positions in a region base register.
  localparam int F_ACC   = 20;
  localparam int F_WR    = 21;
  localparam int F_CACHE = 22;
  localparam int F_EN    = 31;

  // Byte offsets within a region's 16-byte slot.
  localparam logic [3:0] OFS_BASE = 4'h0;
  localparam logic [3:0] OFS_SIZE = 4'h4;

  typedef struct packed {
    logic              en;
    logic              cache_fb;
    logic              write_fb;
    logic              acc_fb;
    logic [PAGE_W-1:0] page;
  } region_base_t;

  // Mask of the page bits that lie inside the region.
  function automatic logic [PAGE_W-1:0] span_mask(input logic [PAGE_W-1:0] size_f);
    return size_f | FLOOR_MASK;
  endfunction

  // True when the page sits inside an open region with the given base and size.
  function automatic logic page_in_region(input logic [PAGE_W-1:0] page,
                                          input logic [PAGE_W-1:0] base,
                                          input logic [PAGE_W-1:0] size_f);
    logic [PAGE_W-1:0] diff;
    diff = (page ^ base) & ~span_mask(size_f);
    return (size_f != '0) && (diff == '0);
  endfunction
endpackage

// File: rtl/prot_region.sv
module prot_region
  import prot_pkg::*;
#(
  parameter int IDX    = 0,
  parameter int CFG_AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [PAGE_W-1:0] req_page,
  output logic              hit,
  output logic              acc_fb,
  output logic              write_fb,
  output logic              cache_fb
);
  localparam int SEL_W = CFG_AW - 4;

  region_base_t      base_q;
  logic [PAGE_W-1:0] size_q;

  logic slot_sel, wr_base, wr_size;
  assign slot_sel = (cfg_addr[CFG_AW-1:4] == SEL_W'(IDX));
  assign wr_base  = cfg_we && slot_sel && (cfg_addr[3:0] == OFS_BASE);
  assign wr_size  = cfg_we && slot_sel && (cfg_addr[3:0] == OFS_SIZE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
    end else begin
      if (wr_base) begin
        base_q.en       <= cfg_wdata[F_EN];
        base_q.cache_fb <= cfg_wdata[F_CACHE];
        base_q.write_fb <= cfg_wdata[F_WR];
        base_q.acc_fb   <= cfg_wdata[F_ACC];
        base_q.page     <= cfg_wdata[PAGE_W-1:0];
      end
      if (wr_size) size_q <= cfg_wdata[PAGE_W-1:0];
    end
  end

  assign hit      = base_q.en && page_in_region(req_page, base_q.page, size_q);
  assign acc_fb   = base_q.acc_fb;
  assign write_fb = base_q.write_fb;
  assign cache_fb = base_q.cache_fb;

  // R13
  spare_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && slot_sel && cfg_addr[3:0] != OFS_BASE && cfg_addr[3:0] != OFS_SIZE)
      |=> ($stable(base_q) && $stable(size_q)));

  // R3
  base_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_base |=> (base_q.page == $past(cfg_wdata[PAGE_W-1:0]) && base_q.en == $past(cfg_wdata[F_EN])));
endmodule

// File: rtl/prot_merge.sv
module prot_merge #(
  parameter int N = 8
) (
  input  logic [N-1:0] hit_vec,
  input  logic [N-1:0] acc_vec,
  input  logic [N-1:0] wr_vec,
  input  logic [N-1:0] cache_vec,
  input  logic         int_hit,
  input  logic         is_write,
  input  logic         is_cacheable,
  output logic         any_acc_fb,
  output logic         allow_d,
  output logic         cache_deny_d
);
  logic any_wr_fb, any_cache_fb;

  assign any_acc_fb   = |(hit_vec & acc_vec);
  assign any_wr_fb    = |(hit_vec & wr_vec);
  assign any_cache_fb = |(hit_vec & cache_vec);

  assign allow_d      = int_hit || !(any_acc_fb || (is_write && any_wr_fb));
  assign cache_deny_d = !int_hit && is_cacheable && any_cache_fb;
endmodule

// File: rtl/prot_checker.sv
module prot_checker
  import prot_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int CFG_AW = $clog2(NUM_REGIONS) + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] int_page,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_cacheable,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic              rsp_cache_deny
);
  logic [PAGE_W-1:0]      req_page;
  logic                   int_hit;
  logic [NUM_REGIONS-1:0] hit_vec, acc_vec, wr_vec, cache_vec;
  logic                   any_acc_fb, allow_d, cache_deny_d;
  logic                   unused_bits;

  assign req_page    = req_addr[ADDR_W-1:PAGE_LSB];
  assign int_hit     = (req_page == int_page);
  assign unused_bits = ^{cfg_wdata[F_EN-1:F_CACHE+1], req_addr[PAGE_LSB-1:0]};

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    prot_region #(.IDX(g), .CFG_AW(CFG_AW)) u_region (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .req_page (req_page),
      .hit      (hit_vec[g]),
      .acc_fb   (acc_vec[g]),
      .write_fb (wr_vec[g]),
      .cache_fb (cache_vec[g])
    );
  end

  prot_merge #(.N(NUM_REGIONS)) u_merge (
    .hit_vec     (hit_vec),
    .acc_vec     (acc_vec),
    .wr_vec      (wr_vec),
    .cache_vec   (cache_vec),
    .int_hit     (int_hit),
    .is_write    (req_write),
    .is_cacheable(req_cacheable),
    .any_acc_fb  (any_acc_fb),
    .allow_d     (allow_d),
    .cache_deny_d(cache_deny_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_allow      <= 1'b0;
      rsp_cache_deny <= 1'b0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_allow      <= req_valid && allow_d;
      rsp_cache_deny <= req_valid && cache_deny_d;
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_allow && !rsp_cache_deny));

  // R12
  internal_exempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && int_hit) |=> (rsp_allow && !rsp_cache_deny));

  // R11
  no_match_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit_vec == '0) |=> (rsp_allow && !rsp_cache_deny));

  // R7
  acc_forbid_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !int_hit && any_acc_fb) |=> !rsp_allow);
endmodule

// File: tb/prot_checker_test.sv
`timescale 1ns/1ps
module prot_checker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] int_page = '0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [35:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_cacheable = 1'b0;
  logic        rsp_valid, rsp_allow, rsp_cache_deny;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [31:0] mbase [8];
  logic [19:0] msize [8];

  always #2 clk = ~clk;

  prot_checker uut (
    .clk(clk), .rst_n(rst_n), .int_page(int_page),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_cacheable(req_cacheable),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_cache_deny(rsp_cache_deny)
  );

  task automatic check3(input string tag, input logic [2:0] got, input logic [2:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: {valid,allow,cache_deny} actual=%b expected=%b", tag, got, exp);
    end
  endtask

  // R3 offsets: base at 0x10*n, size at 0x10*n+4
  task automatic cfg_write(input int region, input int ofs, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'(region * 16 + ofs); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (ofs == 0) mbase[region] = data;
    else if (ofs == 4) msize[region] = data[19:0];
  endtask

  // Range-based model of the requirements.
  function automatic logic [1:0] expect_of(input logic [19:0] page, input bit wr, input bit ca);
    bit acc = 0, wf = 0, cf = 0;
    for (int i = 0; i < 8; i++) begin
      logic [19:0] m, lo, hi;
      if (mbase[i][31] && msize[i] != 0) begin           // R6
        m  = msize[i] | 20'h0000F;                        // R4
        lo = mbase[i][19:0] & ~m;                          // R5
        hi = lo + m;
        if (page >= lo && page <= hi) begin                // R10 accumulate
          acc |= mbase[i][20]; wf |= mbase[i][21]; cf |= mbase[i][22];
        end
      end
    end
    if (page == int_page) return 2'b10;                    // R12
    return {!(acc || (wr && wf)), ca && cf};               // R7 R8 R9 R11
  endfunction

  task automatic one_req(input string tag, input logic [19:0] page, input bit wr, input bit ca);
    logic [1:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_addr = {page, 16'(page * 16'h25 + 16'h3)};
    req_write = wr; req_cacheable = ca;
    e = expect_of(page, wr, ca);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    check3(tag, {rsp_valid, rsp_allow, rsp_cache_deny}, {1'b1, e});
  endtask

  task automatic idle_check();
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    check3("R2 idle", {rsp_valid, rsp_allow, rsp_cache_deny}, 3'b000);
  endtask

  task automatic sweep(input string tag);
    for (int p = 0; p < 256; p++)
      for (int t = 0; t < 4; t++)
        one_req(tag, 20'(p), t[0], t[1]);
    idle_check();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin mbase[i] = '0; msize[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    check3("R1 reset", {rsp_valid, rsp_allow, rsp_cache_deny}, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    idle_check();
    int_page = 20'h00012;
    sweep("R1 R11 empty map");

    // Overlapping configuration inside pages 0..255.
    cfg_write(0, 0, 32'h8010_0010); cfg_write(0, 4, 32'h0000_000F);  // R7 access, covers int page
    cfg_write(1, 0, 32'h8060_0040); cfg_write(1, 4, 32'h0000_003F);  // R8 R9 write+cache
    cfg_write(2, 0, 32'h8010_0020); cfg_write(2, 4, 32'h0000_0000);  // R6 closed by size
    cfg_write(3, 0, 32'h0010_0080); cfg_write(3, 4, 32'h0000_000F);  // R6 not enabled
    cfg_write(4, 0, 32'h8040_00C5); cfg_write(4, 4, 32'h0000_001F);  // R5 stray base bits, R9
    cfg_write(5, 0, 32'h8020_0050); cfg_write(5, 4, 32'h0000_000F);  // R10 overlap with 1
    cfg_write(6, 0, 32'h8010_00A0); cfg_write(6, 4, 32'h0000_0007);  // R4 floor
    cfg_write(7, 0, 32'hFF9A_BCDE); cfg_write(7, 4, 32'h0000_00FF);  // R3 ignored bits, high region
    sweep("R4 R5 R6 R7 R8 R9 R10 R12 map A");

    // High region edges at pages ABC00..ABCFF.
    one_req("R5 high in lo",  20'hABC00, 1'b0, 1'b1);
    one_req("R5 high in hi",  20'hABCFF, 1'b1, 1'b0);
    one_req("R5 high below",  20'hABBFF, 1'b0, 1'b0);
    one_req("R5 high above",  20'hABD00, 1'b1, 1'b1);

    // R13: spare offsets must not disturb region 0 or 1.
    cfg_write(0, 8, 32'h0000_0000); cfg_write(0, 12, 32'h0000_0000);
    cfg_write(1, 8, 32'hFFFF_FFFF); cfg_write(1, 12, 32'h0000_0000);
    one_req("R13 region0 kept", 20'h00015, 1'b0, 1'b0);
    one_req("R13 region1 kept", 20'h00060, 1'b1, 1'b1);

    // R6: disable by enable bit, close by zero size; move internal window.
    cfg_write(0, 0, 32'h0010_0010);
    cfg_write(1, 4, 32'h0000_0000);
    int_page = 20'h00055;
    sweep("R6 R12 map B");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule